// File: doc/BRIEF.md
# Timer Interrupt Vector Generator

This block gathers the interrupt flags of a timer's capture/compare channels 1 to NUM_CH and of its overflow event. It condenses them into one prioritized, even-valued vector word. An interrupt handler reads the word and adds it to its program counter, which lands it in a jump table with one two-byte slot per source. Slot 0 means "nothing to do".

Each read hands back the winning source's code and clears that source's flag alone. Any other pending flags stay set, so the handler can jump back, read again and drain every pending source in priority order before it returns.

Channel 0 stays out of the vector word. It drives its own request line, and that line drops when the interrupt controller acknowledges it.

Top module: `tivg_top`

## Requirements
- R1: After reset all flags are clear, `vec_o` is 0, and both `irq_shared_o` and `irq_ch0_o` are low.
- R2: Channel k (1..NUM_CH, carried on `ch_set_i[k-1]` and `ch_en_i[k-1]`) reads back as code 2*k. The overflow source reads back as code 14. Every code is even.
- R3: When several enabled sources are pending, a read returns the lowest-numbered channel first. Overflow has the lowest priority of all.
- R4: A read clears only the flag whose code it returns. Every other pending flag stays set and is returned by later reads.
- R5: A read while no enabled source is pending returns 0 and changes no flag.
- R6: A source takes part only when its flag and its enable are both 1. A disabled set flag stays latched and gives vector 0 and no request. It appears once its enable is raised.
- R7: `irq_shared_o` is high exactly when a read would return a nonzero code.
- R8: If a source's set pulse and a read that would clear it meet in the same cycle, the flag stays set.
- R9: Channel 0 never appears in `vec_o`. `irq_ch0_o` is its flag ANDed with `ch0_en_i`. `ch0_ack_i` clears that flag, but a same-cycle `ch0_set_i` wins.
- R10: `vec_o` is registered when `vec_rd_i` is sampled high. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_set_i | input | NUM_CH | Set pulses, bit k-1 for channel k |
| ch_en_i | input | NUM_CH | Enables, bit k-1 for channel k |
| ovf_set_i | input | 1 | Overflow set pulse |
| ovf_en_i | input | 1 | Overflow enable |
| ch0_set_i | input | 1 | Channel 0 set pulse |
| ch0_en_i | input | 1 | Channel 0 enable |
| ch0_ack_i | input | 1 | Channel 0 request acknowledge |
| vec_rd_i | input | 1 | Vector word read strobe |
| vec_o | output | VEC_W | Registered vector word |
| irq_shared_o | output | 1 | Request for channels 1..NUM_CH and overflow |
| irq_ch0_o | output | 1 | Channel 0 request |

## Verification
On every cycle the assertions check several local rules. The winner select is at most one-hot. The returned code is even and no larger than 14. A read yields a nonzero code exactly when the shared request was high. The vector holds between reads. A set beats a clear, and a lone clear empties the flag.

Only the directed scenarios can show the rest:
- the code assigned to each source;
- the full drain order across all sources;
- that flags left behind survive a read;
- that a disabled flag stays latched until it is enabled.

// File: rtl/tivg_pkg.sv
package tivg_pkg;
   localparam int MAX_CH   = 6;
   localparam int OVF_CODE = 14;

   // code for source index idx: channels first (idx < num_ch), then overflow
   function automatic int src_code(input int idx, input int num_ch);
      return (idx < num_ch) ? 2 * (idx + 1) : OVF_CODE;
   endfunction
endpackage

// File: rtl/tivg_flag_cell.sv
module tivg_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic en_i,
   output logic flag_o,
   output logic pend_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign pend_o = flag_q & en_i;

   // R8: a set pulse always leaves the flag pending
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
   // R4: a lone clear empties the flag
   assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/tivg_prio_enc.sv
module tivg_prio_enc #(
   parameter int NUM_CH = 6,
   parameter int VEC_W  = 16,
   localparam int NSRC  = NUM_CH + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  pend_i,
   output logic [NSRC-1:0]  win_o,
   output logic [VEC_W-1:0] code_o
);
   import tivg_pkg::*;

   logic [NSRC:0] any_below;
   assign any_below[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_src
         assign any_below[gi+1] = any_below[gi] | pend_i[gi];
         assign win_o[gi]       = pend_i[gi] & ~any_below[gi];
      end
   endgenerate

   always_comb begin
      code_o = '0;
      for (int i = 0; i < NSRC; i++)
         if (win_o[i]) code_o = code_o | VEC_W'(src_code(i, NUM_CH));
   end

   // R3: at most one source wins
   assert_onehot_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_o));
endmodule

// File: rtl/tivg_top.sv
module tivg_top #(
   parameter int NUM_CH = 6,
   parameter int VEC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_set_i,
   input  logic [NUM_CH-1:0] ch_en_i,
   input  logic              ovf_set_i,
   input  logic              ovf_en_i,
   input  logic              ch0_set_i,
   input  logic              ch0_en_i,
   input  logic              ch0_ack_i,
   input  logic              vec_rd_i,
   output logic [VEC_W-1:0]  vec_o,
   output logic              irq_shared_o,
   output logic              irq_ch0_o
);
   import tivg_pkg::*;
   localparam int NSRC = NUM_CH + 1;

   generate
      if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
         $error("tivg_top: NUM_CH out of range 1..6");
      end
      if (VEC_W < 4) begin : g_bad_w
         $error("tivg_top: VEC_W must hold code 14");
      end
   endgenerate

   logic [NSRC-1:0]  set_v, en_v, clr_v, flag_v, pend_v, win_v;
   logic [VEC_W-1:0] code_w, vec_q;
   logic             ch0_flag;

   assign set_v = {ovf_set_i, ch_set_i};
   assign en_v  = {ovf_en_i,  ch_en_i};
   assign clr_v = win_v & {NSRC{vec_rd_i}};

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_flag
         tivg_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n), .set_i(set_v[gi]), .clr_i(clr_v[gi]),
            .en_i(en_v[gi]), .flag_o(flag_v[gi]), .pend_o(pend_v[gi]));
      end
   endgenerate

   tivg_prio_enc #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_enc (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_v), .win_o(win_v), .code_o(code_w));

   tivg_flag_cell u_ch0 (
      .clk(clk), .rst_n(rst_n), .set_i(ch0_set_i), .clr_i(ch0_ack_i),
      .en_i(ch0_en_i), .flag_o(ch0_flag), .pend_o(irq_ch0_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        vec_q <= '0;
      else if (vec_rd_i) vec_q <= code_w;
   end

   assign vec_o        = vec_q;
   assign irq_shared_o = |pend_v;

   // R7: nonzero read result exactly when the shared request was up
   assert_irq_matches_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd_i |=> ((vec_o != '0) == $past(irq_shared_o)));
   // R10: vector holds without a read
   assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_rd_i |=> $stable(vec_o));
   // R2: codes are even and bounded
   assert_code_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_o[0] == 1'b0) && (vec_o <= VEC_W'(OVF_CODE)));
   // R9: acknowledge without set drops channel 0 request
   assert_ch0_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ch0_ack_i && !ch0_set_i) |=> !irq_ch0_o && !ch0_flag);
endmodule

// File: tb/tivg_top_tb_top.sv
`timescale 1ns/100ps
module tivg_top_tb_top;
   localparam int NCH = 6;
   localparam int VW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] ch_set = '0, ch_en = '0;
   logic ovf_set = 0, ovf_en = 0, ch0_set = 0, ch0_en = 0, ch0_ack = 0, rd = 0;
   logic [VW-1:0] vec;
   logic irq_sh, irq0;
   int n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   tivg_top #(.NUM_CH(NCH), .VEC_W(VW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ch_set_i(ch_set), .ch_en_i(ch_en),
      .ovf_set_i(ovf_set), .ovf_en_i(ovf_en), .ch0_set_i(ch0_set),
      .ch0_en_i(ch0_en), .ch0_ack_i(ch0_ack), .vec_rd_i(rd),
      .vec_o(vec), .irq_shared_o(irq_sh), .irq_ch0_o(irq0));

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [NCH-1:0] m, input logic o);
      @(negedge clk); ch_set = m; ovf_set = o;
      @(negedge clk); ch_set = '0; ovf_set = 0;
   endtask

   task automatic read_vec(output int code);
      @(negedge clk); rd = 1;
      @(negedge clk); rd = 0;
      code = int'(vec);
   endtask

   task automatic t_reset;
      check("R1 vec", int'(vec), 0);
      check("R1 irq_shared", int'(irq_sh), 0);
      check("R1 irq_ch0", int'(irq0), 0);
   endtask

   task automatic t_codes;
      int c;
      ch_en = '1; ovf_en = 1;
      for (int k = 1; k <= NCH; k++) begin
         pulse(NCH'(1) << (k-1), 0);
         read_vec(c);
         check($sformatf("R2 ch%0d code", k), c, 2*k);
      end
      pulse('0, 1);
      read_vec(c); check("R2 overflow code", c, 14);
      read_vec(c); check("R5 empty read", c, 0);
   endtask

   task automatic t_drain;
      int c;
      pulse('1, 1);
      for (int k = 1; k <= NCH; k++) begin
         check("R7 irq before read", int'(irq_sh), 1);
         read_vec(c);
         check($sformatf("R3 R4 drain step %0d", k), c, 2*k);
      end
      read_vec(c); check("R3 overflow last", c, 14);
      check("R7 irq after drain", int'(irq_sh), 0);
   endtask

   task automatic t_partial;
      int c;
      pulse(6'b010100, 0);   // channels 3 and 5
      read_vec(c); check("R4 first", c, 6);
      check("R4 other stays", int'(irq_sh), 1);
      read_vec(c); check("R4 second", c, 10);
      read_vec(c); check("R5 empty", c, 0);
   endtask

   task automatic t_disabled;
      int c;
      ch_en = '0; ovf_en = 0;
      pulse(6'b000100, 0);
      check("R6 no irq when disabled", int'(irq_sh), 0);
      read_vec(c); check("R6 vec zero when disabled", c, 0);
      @(negedge clk); ch_en = 6'b000100;
      @(negedge clk);
      check("R6 latched flag requests", int'(irq_sh), 1);
      read_vec(c); check("R6 latched code", c, 6);
      ch_en = '1; ovf_en = 1;
   endtask

   task automatic t_collide;
      int c;
      pulse(6'b000001, 0);
      @(negedge clk); rd = 1; ch_set = 6'b000001;
      @(negedge clk); rd = 0; ch_set = '0;
      check("R8 returned code", int'(vec), 2);
      check("R8 flag stays", int'(irq_sh), 1);
      read_vec(c); check("R8 second read", c, 2);
      check("R8 now clear", int'(irq_sh), 0);
   endtask

   task automatic t_hold;
      pulse(6'b000010, 0);
      read_vec(c_dummy);
      pulse(6'b000001, 1);
      repeat (3) @(negedge clk);
      check("R10 vector held", int'(vec), 4);
      read_vec(c_dummy); check("R10 updated", c_dummy, 2);
      read_vec(c_dummy); check("R10 overflow", c_dummy, 14);
   endtask
   int c_dummy;

   task automatic t_ch0;
      int c;
      ch0_en = 1;
      @(negedge clk); ch0_set = 1;
      @(negedge clk); ch0_set = 0;
      check("R9 ch0 irq", int'(irq0), 1);
      check("R9 shared stays low", int'(irq_sh), 0);
      read_vec(c); check("R9 ch0 not in vector", c, 0);
      check("R9 ch0 survives read", int'(irq0), 1);
      @(negedge clk); ch0_ack = 1; ch0_set = 1;
      @(negedge clk); ch0_ack = 0; ch0_set = 0;
      check("R9 set beats ack", int'(irq0), 1);
      @(negedge clk); ch0_ack = 1;
      @(negedge clk); ch0_ack = 0;
      check("R9 ack clears", int'(irq0), 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            t_reset();
            rst_n = 1;
            t_codes();
            t_drain();
            t_partial();
            t_disabled();
            t_collide();
            t_hold();
            t_ch0();
         end
         begin
            repeat (20000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule